// File: doc/BRIEF.md
# Clock Control and Status Register

This block is a single 32-bit control and status word that sits at one offset of a clock generator's register space. Software turns on three oscillators (a multi-speed internal one, a fast internal one and an external one) and three PLLs (one main and two auxiliary) by setting enable bits, and it also sets an oscillator range select, four configuration bits, an external-oscillator bypass bit and a clock security enable. Hardware reports the state of each oscillator and PLL through read-only ready flags that come from asynchronous lock and stable inputs.

Hardware can override software. A low-power entry pulse clears all three PLL enables. While the main PLL drives the system clock, software cannot switch it off. The clock security enable can only be set by software and only reset clears it. The bypass bit keeps its value through reset, so a board that feeds the external clock input from a ready-made clock stays set up across a reset.

The bus side is a plain slave: select, write strobe, address, four byte enables and write data. Writes complete in the cycle they are presented, and read data is combinational.

Top module: `clk_ctrl_reg`

## Requirements
- R1: Once reset has been released, the register reads 0x0000_0063 with bit 18 masked off. This assumes the multi-speed oscillator stable input is high and all other ready inputs are low. The reset value is multi-speed enable (bit 0) = 1, multi-speed ready (bit 1) = 1, and range select (bits 7:4) = 6.
- R2: The bypass bit (bit 18) keeps its value through reset. Only a write to byte lane 2 changes it.
- R3: A write at offset 0 updates only the byte lanes whose enable is 1. Lane n is bits 8n+7:8n. Without a write or a low-power pulse, the stored bits do not change.
- R4: Bits 31:30, 23:20 and 15:12 always read 0, and writing to them has no effect.
- R5: Bits 29, 27 and 25 show the lock inputs of auxiliary PLL 2, auxiliary PLL 1 and the main PLL. Bits 17, 10 and 1 show the stable inputs of the external, fast internal and multi-speed oscillators. Each flag shows its input value two clock edges after the input changes. Writes to these bits have no effect.
- R6: A one-cycle low-power entry pulse clears the PLL enables at bits 28, 26 and 24 on that edge. If a write to those bits arrives in the same cycle, the pulse wins.
- R7: When the system clock source input is 2'b11 (main PLL), a write of 0 to bit 24 while bit 24 is 1 is ignored. Bits 28 and 26 are still written as normal.
- R8: Bit 19 (clock security enable) is set by writing 1. Writing 0 leaves it set, and only reset clears it.
- R9: Writes to any offset other than 0 change nothing, and reads of any other offset return 0.
- R10: The enable, bypass, security, range and configuration outputs always equal the matching stored bits. The configuration output is {bit 11, bit 9, bit 3, bit 2}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Slave select |
| bus_we | input | 1 | Write strobe (0 = read) |
| bus_addr | input | ADDR_W | Byte offset |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 unless the offset matches |
| pll_lock_in | input | 3 | Asynchronous lock inputs: [0] main, [1] aux 1, [2] aux 2 |
| osc_stable_in | input | 3 | Asynchronous stable inputs: [0] multi-speed, [1] fast internal, [2] external |
| lp_enter | input | 1 | Low-power entry pulse |
| sysclk_src | input | 2 | Current system clock source, 2'b11 = main PLL |
| osc_en | output | 3 | Oscillator enables, ordered as osc_stable_in |
| pll_en | output | 3 | PLL enables, ordered as pll_lock_in |
| ext_bypass | output | 1 | External oscillator bypass |
| css_en | output | 1 | Clock security enable |
| ms_range | output | 4 | Multi-speed oscillator range select |
| osc_cfg | output | 4 | Configuration bits {11, 9, 3, 2} |

## Verification
Three kinds of event can land on the PLL enable bits in the same cycle: a low-power entry pulse, a software write, and the main-PLL hold. The bench forces these collisions on purpose. It drives the pulse in the same cycle as a write of ones to lane 3. It also writes 0 to bit 24 with the source input at 2'b11, both with and without the pulse. The read-back is judged against a bench model in which the pulse beats both the write and the hold. The bench also sweeps every byte-enable combination against several data patterns to check lane masking around the read-only, reserved and set-only bits.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;

  localparam int B_MS_EN   = 0;
  localparam int B_MS_RDY  = 1;
  localparam int B_FI_EN   = 8;
  localparam int B_FI_RDY  = 10;
  localparam int B_EXT_EN  = 16;
  localparam int B_EXT_RDY = 17;
  localparam int B_BYP     = 18;
  localparam int B_CSS     = 19;
  localparam int B_PLL0_EN = 24;
  localparam int B_PLL0_RDY= 25;
  localparam int B_PLL1_EN = 26;
  localparam int B_PLL1_RDY= 27;
  localparam int B_PLL2_EN = 28;
  localparam int B_PLL2_RDY= 29;

  localparam logic [DATA_W-1:0] RW_MASK  = 32'h150D_0BFD;
  localparam logic [DATA_W-1:0] PLL_MASK = 32'h1500_0000;
  localparam logic [DATA_W-1:0] RES_MASK = 32'hC0F0_F000;
  localparam logic [DATA_W-1:0] BYP_MASK = 32'h0004_0000;
  localparam logic [DATA_W-1:0] RST_WORD = 32'h0000_0061;

  localparam logic [1:0] SRC_MAIN_PLL = 2'b11;
endpackage

// File: rtl/clk_ctrl_sync.sv
module clk_ctrl_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/clk_ctrl_core.sv
module clk_ctrl_core
  import clk_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lp_enter,
  input  logic              main_is_sys,
  output logic [DATA_W-1:0] ctl_word
);
  logic [DATA_W-1:0] ctl_q, ctl_d;
  logic              ctl_load;
  logic              byp_q, byp_load;

  always_comb begin
    ctl_d = ctl_q;
    for (int l = 0; l < LANES; l++) begin
      if (wr_hit && be[l]) ctl_d[8*l +: 8] = wdata[8*l +: 8] & RW_MASK[8*l +: 8];
    end
    ctl_d[B_CSS] = ctl_d[B_CSS] | ctl_q[B_CSS];
    if (main_is_sys && ctl_q[B_PLL0_EN]) ctl_d[B_PLL0_EN] = 1'b1;
    if (lp_enter) ctl_d = ctl_d & ~PLL_MASK;
    ctl_load = wr_hit | lp_enter;
    byp_load = wr_hit & be[B_BYP/8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= RST_WORD;
    else if (ctl_load) ctl_q <= ctl_d & ~BYP_MASK;
  end

  always_ff @(posedge clk) begin
    if (byp_load) byp_q <= ctl_d[B_BYP];
  end

  assign ctl_word = ctl_q | ({{(DATA_W-1){1'b0}}, byp_q} << B_BYP);

  assert_lp_clears_pll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lp_enter |=> ((ctl_q & PLL_MASK) == '0));
  assert_main_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (main_is_sys && ctl_q[B_PLL0_EN] && !lp_enter) |=> ctl_q[B_PLL0_EN]);
  assert_css_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[B_CSS] |=> ctl_q[B_CSS]);
  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !lp_enter) |=> $stable(ctl_q));
  assert_byp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !byp_load |=> $stable(byp_q));
endmodule

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg
  import clk_ctrl_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [2:0]        pll_lock_in,
  input  logic [2:0]        osc_stable_in,
  input  logic              lp_enter,
  input  logic [1:0]        sysclk_src,
  output logic [2:0]        osc_en,
  output logic [2:0]        pll_en,
  output logic              ext_bypass,
  output logic              css_en,
  output logic [3:0]        ms_range,
  output logic [3:0]        osc_cfg
);
  localparam int FLAGS = 6;

  logic [1:0]        rst_pipe_q;
  logic              rst_q;
  logic              addr_hit, wr_hit, rd_hit;
  logic [FLAGS-1:0]  flag_async, flag_sync;
  logic [DATA_W-1:0] ctl_word, sts_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q = rst_pipe_q[1];

  assign addr_hit   = bus_sel && (bus_addr == REG_OFFSET);
  assign wr_hit     = addr_hit && bus_we;
  assign rd_hit     = addr_hit && !bus_we;
  assign flag_async = {pll_lock_in, osc_stable_in};

  clk_ctrl_sync #(.W(FLAGS), .RST_VAL(6'b000_001)) u_flag_sync (
    .clk      (clk),
    .rst_n    (rst_q),
    .async_in (flag_async),
    .sync_out (flag_sync)
  );

  clk_ctrl_core u_core (
    .clk         (clk),
    .rst_n       (rst_q),
    .wr_hit      (wr_hit),
    .be          (bus_be),
    .wdata       (bus_wdata),
    .lp_enter    (lp_enter),
    .main_is_sys (sysclk_src == SRC_MAIN_PLL),
    .ctl_word    (ctl_word)
  );

  always_comb begin
    sts_word             = '0;
    sts_word[B_MS_RDY]   = flag_sync[0];
    sts_word[B_FI_RDY]   = flag_sync[1];
    sts_word[B_EXT_RDY]  = flag_sync[2];
    sts_word[B_PLL0_RDY] = flag_sync[3];
    sts_word[B_PLL1_RDY] = flag_sync[4];
    sts_word[B_PLL2_RDY] = flag_sync[5];
    bus_rdata = rd_hit ? (ctl_word | sts_word) : '0;
  end

  assign osc_en     = {ctl_word[B_EXT_EN], ctl_word[B_FI_EN], ctl_word[B_MS_EN]};
  assign pll_en     = {ctl_word[B_PLL2_EN], ctl_word[B_PLL1_EN], ctl_word[B_PLL0_EN]};
  assign ext_bypass = ctl_word[B_BYP];
  assign css_en     = ctl_word[B_CSS];
  assign ms_range   = ctl_word[7:4];
  assign osc_cfg    = {ctl_word[11], ctl_word[9], ctl_word[3], ctl_word[2]};

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_rdata & RES_MASK) == '0);
  assert_miss_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_hit |-> (bus_rdata == '0));
endmodule

// File: tb/clk_ctrl_reg_tb_top.sv
module clk_ctrl_reg_tb_top;
  localparam logic [31:0] RW_MASK  = 32'h150D_0BFD;
  localparam logic [31:0] PLL_MASK = 32'h1500_0000;
  localparam logic [31:0] RES_MASK = 32'hC0F0_F000;
  localparam logic [31:0] BYP_BIT  = 32'h0004_0000;
  localparam logic [31:0] CSS_BIT  = 32'h0008_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  pll_lock_in, osc_stable_in;
  logic        lp_enter;
  logic [1:0]  sysclk_src;
  logic [2:0]  osc_en, pll_en;
  logic        ext_bypass, css_en;
  logic [3:0]  ms_range, osc_cfg;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl;
  logic [31:0] rv;

  always #5 clk = ~clk;

  clk_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pll_lock_in(pll_lock_in),
    .osc_stable_in(osc_stable_in), .lp_enter(lp_enter),
    .sysclk_src(sysclk_src), .osc_en(osc_en), .pll_en(pll_en),
    .ext_bypass(ext_bypass), .css_en(css_en), .ms_range(ms_range),
    .osc_cfg(osc_cfg)
  );

  function automatic logic [31:0] flags_exp();
    logic [31:0] f = '0;
    f[1]  = osc_stable_in[0];
    f[10] = osc_stable_in[1];
    f[17] = osc_stable_in[2];
    f[25] = pll_lock_in[0];
    f[27] = pll_lock_in[1];
    f[29] = pll_lock_in[2];
    return f;
  endfunction

  function automatic logic [31:0] mdl_next(logic [31:0] cur, logic hit,
      logic [3:0] be, logic [31:0] d, logic [1:0] src, logic lp);
    logic [31:0] m = cur;
    if (hit)
      for (int l = 0; l < 4; l++)
        if (be[l]) m[8*l +: 8] = d[8*l +: 8] & RW_MASK[8*l +: 8];
    m[19] = m[19] | cur[19];
    if (src == 2'b11 && cur[24]) m[24] = 1'b1;
    if (lp) m = m & ~PLL_MASK;
    return m;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk);
    mdl = mdl_next(mdl, a == 8'h00, be, d, sysclk_src, lp_enter);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; lp_enter = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mdl = 32'h0000_0061 | (mdl & BYP_BIT);
  endtask

  task automatic rd_chk(string tag);
    rd(8'h00, rv);
    chk(tag, rv, mdl | flags_exp());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0;
    pll_lock_in = 3'b000; osc_stable_in = 3'b001; lp_enter = 0; sysclk_src = 2'b00;
    mdl = '0;
    @(negedge clk);
    do_reset();
    // R1 reset value with bypass masked
    rd(8'h00, rv);
    chk("R1 reset value", rv & ~BYP_BIT, 32'h0000_0063);
    wr(8'h00, 4'b0100, 32'h0);
    rd_chk("R2 bypass cleared by write");

    // R3 R4 R5 sweep of byte enables and patterns
    for (int b = 0; b < 16; b++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] d;
        case (p)
          0: d = 32'hFFFF_FFFF;
          1: d = 32'h0000_0000;
          2: d = 32'hA5A5_A5A5;
          default: d = 32'h5A5A_5A5A;
        endcase
        wr(8'h00, b[3:0], d);
        rd_chk("R3 lane write");
      end
    end
    wr(8'h00, 4'hF, 32'hFFFF_FFFF);
    rd(8'h00, rv);
    chk("R4 reserved read zero", rv & RES_MASK, 32'h0);

    // R10 output mirror
    wr(8'h00, 4'hF, 32'hFFFF_F8AD);
    chk("R10 outputs", {20'h0, osc_en, pll_en, ext_bypass, css_en, ms_range, osc_cfg},
        {20'h0, mdl[16], mdl[8], mdl[0], mdl[28], mdl[26], mdl[24], mdl[18], mdl[19],
         mdl[7:4], mdl[11], mdl[9], mdl[3], mdl[2]});

    // R5 ready flags latency
    pll_lock_in = 3'b101; osc_stable_in = 3'b110;
    @(posedge clk); @(negedge clk);
    rd(8'h00, rv);
    chk("R5 flags not yet visible", rv, mdl | 32'h0000_0002);
    @(posedge clk); @(negedge clk);
    rd_chk("R5 flags after two edges");
    wr(8'h00, 4'hF, 32'h0000_0000);
    rd_chk("R5 flags ignore write");

    // R7 main PLL hold
    wr(8'h00, 4'b1000, 32'h1500_0000);
    sysclk_src = 2'b11;
    wr(8'h00, 4'b1000, 32'h0000_0000);
    rd(8'h00, rv);
    chk("R7 main hold", rv & PLL_MASK, 32'h0100_0000);
    sysclk_src = 2'b10;
    wr(8'h00, 4'b1000, 32'h0000_0000);
    rd(8'h00, rv);
    chk("R7 release when not main", rv & PLL_MASK, 32'h0);

    // R6 low-power entry
    sysclk_src = 2'b00;
    wr(8'h00, 4'b1000, 32'h1500_0000);
    lp_enter = 1'b1;
    @(posedge clk); mdl = mdl & ~PLL_MASK;
    @(negedge clk); lp_enter = 1'b0;
    rd(8'h00, rv);
    chk("R6 lp clears", rv & PLL_MASK, 32'h0);
    lp_enter = 1'b1;
    wr(8'h00, 4'b1000, 32'h1500_0000);
    rd(8'h00, rv);
    chk("R6 lp beats write", rv & PLL_MASK, 32'h0);
    wr(8'h00, 4'b1000, 32'h0100_0000);
    sysclk_src = 2'b11;
    lp_enter = 1'b1;
    wr(8'h00, 4'b1000, 32'h0000_0000);
    rd(8'h00, rv);
    chk("R6 lp beats main hold", rv & PLL_MASK, 32'h0);
    sysclk_src = 2'b00;

    // R8 set-only security enable
    wr(8'h00, 4'b0100, 32'h0008_0000);
    wr(8'h00, 4'b0100, 32'h0000_0000);
    rd(8'h00, rv);
    chk("R8 css stays set", rv & CSS_BIT, CSS_BIT);

    // R9 address decode
    wr(8'h04, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R9 miss write ignored");
    rd(8'h04, rv);
    chk("R9 miss read zero", rv, 32'h0);

    // R2 bypass survives reset, R8 reset clears css
    wr(8'h00, 4'b0100, 32'h0004_0000);
    do_reset();
    rd(8'h00, rv);
    chk("R2 bypass kept 1", rv & BYP_BIT, BYP_BIT);
    chk("R8 css cleared by reset", rv & CSS_BIT, 32'h0);
    wr(8'h00, 4'b0100, 32'h0000_0000);
    do_reset();
    rd(8'h00, rv);
    chk("R2 bypass kept 0", rv & BYP_BIT, 32'h0);
    rd_chk("R1 reset with flags");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule